// File: doc/BRIEF.md
# Guest Exception Intercept Arbiter

This block sits in the event path of a virtualising core. It inspects every exception or interrupt a guest raises and makes one of two choices. It can exit to the host, or it can let the event be delivered inside the guest. A 32-bit per-vector mask names the exception vectors the host wants to see. Each event comes with a source code. For an exit, that code sets which instruction pointer is saved. The vector sets what exit information goes with it: an error code, a faulting address, or zero. The decision is registered and appears one clock after the event is presented.

The block remembers whether the guest is still delivering an earlier exception. A new exception that arrives during that window is checked against the mask on its own first. Only if it is not intercepted is it combined into a double fault. A further fault while the double fault is being delivered becomes a shutdown. The double fault and the shutdown each have their own intercept. A shutdown that is not intercepted parks the block until reset. The core pulses a completion input when a delivery finishes, and this returns the block to its idle state.

Top module: `exc_intercept_arb`

## Requirements
- R1: An event with source code 1 (external interrupt) or 2 (INTn software interrupt) never consults the mask, even for vectors 0 to 31. One cycle later the block raises `deliver_valid` with `deliver_vec` equal to the event vector, and `exit_valid` stays low.
- R2: A source-0 (hardware) or source-3 event whose mask bit is set raises `exit_valid` one cycle later, with `exit_code` = 0x40 + vector. If the mask bit is clear, the block raises `deliver_valid` instead and enters the delivering state. `exit_valid` and `deliver_valid` are never high together.
- R3: An exception raised while an earlier one is being delivered is checked against the mask first. If it is intercepted, the exit reports the new vector, with `exit_prior_valid` = 1 and `exit_prior_vec` = the earlier vector.
- R4: A nested exception that is not intercepted combines into a double fault (vector 8). If mask bit 8 is set, the block exits with code 0x48, and exit info 1, exit info 2 and the saved pointer all zero. Otherwise it delivers vector 8.
- R5: A fault arriving while a double fault is being delivered is first checked against its own mask bit. If intercepted, it exits with prior vector 8. If not, it becomes a shutdown. With `shut_icpt` high, the shutdown exits with code 0x7F. With `shut_icpt` low, `shutdown` goes high and stays high until reset, and all later events produce no exit and no delivery.
- R6: For source code 3 (INT3, INTO or BOUND), the saved pointer is `ev_ip_cur`.
- R7: An event with source code 4 (single-byte ICEBP, vector 1) never exits. It is delivered.
- R8: For a source-0 vector 1 debug exit, the saved pointer is `ev_ip_cur` when `ev_db_trap` = 0 (fault) and `ev_ip_next` when `ev_db_trap` = 1 (trap).
- R9: For vectors 10, 11, 12, 13 and 17, exit info 1 is the zero-extended `ev_errc` and exit info 2 is zero.
- R10: For vector 14, exit info 1 is the zero-extended `ev_errc` and exit info 2 is `ev_fault_addr`.
- R11: Mask bits 2 and 9 are ignored. Vectors 32 and above are never intercepted.
- R12: Intercepted vectors other than those in R9 and R10 report both exit info fields as zero. A source-0 exit other than vector 1 or 8 saves `ev_ip_cur`.
- R13: A `dlv_done` pulse while no event is presented ends the delivering state, so the next exception is not treated as nested.
- R14: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_vector | input | 8 | Event vector number |
| ev_src | input | 3 | Source: 0 hw exception, 1 external int, 2 INTn, 3 INT3/INTO/BOUND, 4 ICEBP |
| ev_errc | input | 32 | Error code of the event |
| ev_fault_addr | input | 64 | Faulting address (page fault) |
| ev_ip_cur | input | 64 | Pointer of the current instruction |
| ev_ip_next | input | 64 | Pointer of the following instruction |
| ev_db_trap | input | 1 | Debug exception is trap-type (1) or fault-type (0) |
| exc_mask | input | 32 | Per-vector intercept mask |
| shut_icpt | input | 1 | Shutdown intercept enable |
| dlv_done | input | 1 | In-guest delivery has completed |
| exit_valid | output | 1 | One-cycle exit strobe |
| exit_code | output | 8 | Exit reason code |
| exit_info1 | output | 64 | Exit information 1 |
| exit_info2 | output | 64 | Exit information 2 |
| exit_ip | output | 64 | Saved instruction pointer |
| exit_prior_valid | output | 1 | A prior event was being delivered |
| exit_prior_vec | output | 8 | Vector of that prior event |
| deliver_valid | output | 1 | One-cycle delivery strobe |
| deliver_vec | output | 8 | Vector to deliver |
| shutdown | output | 1 | Sticky shutdown state |

## Verification
The case that is hardest to reach from the ports is the third-level fault, because the block must be inside a double-fault delivery before it happens. The stimulus builds up to it step by step. It delivers an unintercepted exception, then raises a second one with its mask bit and the double-fault bit both clear, which produces a delivered vector 8. With that state set, it presents a third fault, once with `shut_icpt` high and once with it low. Nested intercepts with a recorded prior vector use the same approach, holding `dlv_done` low between events.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  typedef enum logic [2:0] {
    SRC_HW     = 3'd0,
    SRC_EXTINT = 3'd1,
    SRC_SWINT  = 3'd2,
    SRC_INSN   = 3'd3,
    SRC_ICEBP  = 3'd4
  } ev_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DLV1  = 2'd1,
    ST_DLVDF = 2'd2,
    ST_SHUT  = 2'd3
  } nest_st_e;

  typedef enum logic [1:0] {
    EX_NORM = 2'd0,
    EX_DF   = 2'd1,
    EX_SHUT = 2'd2
  } exit_kind_e;

  localparam int unsigned DB_VEC  = 1;
  localparam int unsigned DF_VEC  = 8;
  localparam int unsigned PF_VEC  = 14;
  localparam int unsigned RSV_A   = 2;
  localparam int unsigned RSV_B   = 9;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_arb_pkg::*;
#(
  parameter int unsigned VW   = 8,
  parameter int unsigned XW   = 64,
  parameter int unsigned ECW  = 32,
  parameter int unsigned NVEC = 32
) (
  input  logic [2:0]      src,
  input  logic [VW-1:0]   vector,
  input  logic [NVEC-1:0] mask,
  input  logic [ECW-1:0]  errc,
  input  logic [XW-1:0]   fault_addr,
  input  logic [XW-1:0]   ip_cur,
  input  logic [XW-1:0]   ip_next,
  input  logic            db_trap,
  output logic            consult,
  output logic            hit,
  output logic            df_hit,
  output logic [XW-1:0]   info1,
  output logic [XW-1:0]   info2,
  output logic [XW-1:0]   saved_ip
);
  localparam int unsigned IDXW = $clog2(NVEC);

  logic [NVEC-1:0] eff_mask;
  logic            in_range;

  always_comb begin
    eff_mask        = mask;
    eff_mask[RSV_A] = 1'b0;
    eff_mask[RSV_B] = 1'b0;
  end

  assign consult  = (src == SRC_HW) || (src == SRC_INSN);
  assign in_range = (vector < VW'(NVEC));
  assign hit      = consult && in_range && eff_mask[vector[IDXW-1:0]];
  assign df_hit   = eff_mask[DF_VEC];

  always_comb begin
    info1 = '0;
    info2 = '0;
    case (vector)
      VW'(10), VW'(11), VW'(12), VW'(13), VW'(17): info1 = XW'(errc);
      VW'(PF_VEC): begin
        info1 = XW'(errc);
        info2 = fault_addr;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (src == SRC_INSN)               saved_ip = ip_cur;
    else if (vector == VW'(DB_VEC))    saved_ip = db_trap ? ip_next : ip_cur;
    else if (vector == VW'(DF_VEC))    saved_ip = '0;
    else                               saved_ip = ip_cur;
  end
endmodule

// File: rtl/exc_nest_fsm.sv
module exc_nest_fsm
  import exc_arb_pkg::*;
#(
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [VW-1:0] vector,
  input  logic          consult,
  input  logic          hit,
  input  logic          df_hit,
  input  logic          shut_icpt,
  input  logic          dlv_done,
  output logic          act_exit,
  output logic          act_dlv,
  output logic [VW-1:0] dlv_vec,
  output exit_kind_e    exit_kind,
  output logic          prior_valid,
  output logic [VW-1:0] prior_vec,
  output logic          in_shutdown
);
  nest_st_e      st_q, st_d;
  logic [VW-1:0] prior_q, prior_d;

  always_comb begin
    st_d        = st_q;
    prior_d     = prior_q;
    act_exit    = 1'b0;
    act_dlv     = 1'b0;
    dlv_vec     = vector;
    exit_kind   = EX_NORM;
    prior_valid = 1'b0;
    if (st_q == ST_SHUT) begin
      st_d = ST_SHUT;
    end else if (ev_valid) begin
      if (!consult) begin
        act_dlv = 1'b1;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (hit) act_exit = 1'b1;
            else begin
              act_dlv = 1'b1;
              st_d    = ST_DLV1;
              prior_d = vector;
            end
          end
          ST_DLV1: begin
            st_d = ST_IDLE;
            if (hit) begin
              act_exit    = 1'b1;
              prior_valid = 1'b1;
            end else if (df_hit) begin
              act_exit  = 1'b1;
              exit_kind = EX_DF;
            end else begin
              act_dlv = 1'b1;
              dlv_vec = VW'(DF_VEC);
              st_d    = ST_DLVDF;
              prior_d = VW'(DF_VEC);
            end
          end
          default: begin
            st_d = ST_IDLE;
            if (hit) begin
              act_exit    = 1'b1;
              prior_valid = 1'b1;
            end else if (shut_icpt) begin
              act_exit  = 1'b1;
              exit_kind = EX_SHUT;
            end else begin
              st_d = ST_SHUT;
            end
          end
        endcase
      end
    end else if (dlv_done) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      prior_q <= '0;
    end else begin
      st_q <= st_d;
      if (prior_d != prior_q) prior_q <= prior_d;
    end
  end

  assign prior_vec   = prior_q;
  assign in_shutdown = (st_q == ST_SHUT);
endmodule

// File: rtl/exc_intercept_arb.sv
module exc_intercept_arb
  import exc_arb_pkg::*;
#(
  parameter int unsigned VW        = 8,
  parameter int unsigned XW        = 64,
  parameter int unsigned ECW       = 32,
  parameter int unsigned NVEC      = 32,
  parameter int unsigned CW        = 8,
  parameter logic [7:0]  EXIT_BASE = 8'h40,
  parameter logic [7:0]  SHUT_CODE = 8'h7F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic [VW-1:0]   ev_vector,
  input  logic [2:0]      ev_src,
  input  logic [ECW-1:0]  ev_errc,
  input  logic [XW-1:0]   ev_fault_addr,
  input  logic [XW-1:0]   ev_ip_cur,
  input  logic [XW-1:0]   ev_ip_next,
  input  logic            ev_db_trap,
  input  logic [NVEC-1:0] exc_mask,
  input  logic            shut_icpt,
  input  logic            dlv_done,
  output logic            exit_valid,
  output logic [CW-1:0]   exit_code,
  output logic [XW-1:0]   exit_info1,
  output logic [XW-1:0]   exit_info2,
  output logic [XW-1:0]   exit_ip,
  output logic            exit_prior_valid,
  output logic [VW-1:0]   exit_prior_vec,
  output logic            deliver_valid,
  output logic [VW-1:0]   deliver_vec,
  output logic            shutdown
);
  logic          consult, hit, df_hit;
  logic [XW-1:0] c_info1, c_info2, c_ip;
  logic          act_exit, act_dlv, pri_v;
  logic [VW-1:0] dlv_vec, pri_vec;
  exit_kind_e    kind;

  logic [CW-1:0] code_d;
  logic [XW-1:0] info1_d, info2_d, ip_d;

  exc_classify #(.VW(VW), .XW(XW), .ECW(ECW), .NVEC(NVEC)) u_cls (
    .src(ev_src), .vector(ev_vector), .mask(exc_mask), .errc(ev_errc),
    .fault_addr(ev_fault_addr), .ip_cur(ev_ip_cur), .ip_next(ev_ip_next),
    .db_trap(ev_db_trap), .consult(consult), .hit(hit), .df_hit(df_hit),
    .info1(c_info1), .info2(c_info2), .saved_ip(c_ip)
  );

  exc_nest_fsm #(.VW(VW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .vector(ev_vector),
    .consult(consult), .hit(hit), .df_hit(df_hit), .shut_icpt(shut_icpt),
    .dlv_done(dlv_done), .act_exit(act_exit), .act_dlv(act_dlv),
    .dlv_vec(dlv_vec), .exit_kind(kind), .prior_valid(pri_v),
    .prior_vec(pri_vec), .in_shutdown(shutdown)
  );

  always_comb begin
    code_d  = EXIT_BASE + CW'(ev_vector);
    info1_d = c_info1;
    info2_d = c_info2;
    ip_d    = c_ip;
    case (kind)
      EX_DF: begin
        code_d  = EXIT_BASE + CW'(DF_VEC);
        info1_d = '0;
        info2_d = '0;
        ip_d    = '0;
      end
      EX_SHUT: begin
        code_d  = SHUT_CODE;
        info1_d = '0;
        info2_d = '0;
        ip_d    = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_valid       <= 1'b0;
      deliver_valid    <= 1'b0;
      exit_code        <= '0;
      exit_info1       <= '0;
      exit_info2       <= '0;
      exit_ip          <= '0;
      exit_prior_valid <= 1'b0;
      exit_prior_vec   <= '0;
      deliver_vec      <= '0;
    end else begin
      exit_valid    <= act_exit;
      deliver_valid <= act_dlv;
      if (act_exit) begin
        exit_code        <= code_d;
        exit_info1       <= info1_d;
        exit_info2       <= info2_d;
        exit_ip          <= ip_d;
        exit_prior_valid <= pri_v;
        exit_prior_vec   <= pri_v ? pri_vec : '0;
      end
      if (act_dlv) deliver_vec <= dlv_vec;
    end
  end
endmodule

// File: rtl/exc_arb_checker.sv
module exc_arb_checker #(
  parameter int unsigned VW        = 8,
  parameter int unsigned CW        = 8,
  parameter logic [7:0]  EXIT_BASE = 8'h40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic [2:0]    ev_src,
  input logic [VW-1:0] ev_vector,
  input logic          exit_valid,
  input logic [CW-1:0] exit_code,
  input logic          deliver_valid,
  input logic [VW-1:0] deliver_vec,
  input logic          shutdown
);
  a_r1_interrupt_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && (ev_src == 3'd1 || ev_src == 3'd2) && !shutdown
    |=> deliver_valid && !exit_valid && deliver_vec == $past(ev_vector));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(exit_valid && deliver_valid));

  a_r7_icebp_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_src == 3'd4 && !shutdown |=> deliver_valid && !exit_valid);

  a_r11_vec2_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_vector == VW'(2) && !shutdown
    |=> !(exit_valid && exit_code == EXIT_BASE + CW'(2)));

  a_r5_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  a_r5_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !exit_valid && !deliver_valid);

  a_r2_no_event_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !exit_valid && !deliver_valid);
endmodule

bind exc_intercept_arb exc_arb_checker #(.VW(VW), .CW(CW), .EXIT_BASE(EXIT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src),
  .ev_vector(ev_vector), .exit_valid(exit_valid), .exit_code(exit_code),
  .deliver_valid(deliver_valid), .deliver_vec(deliver_vec), .shutdown(shutdown)
);

// File: tb/tb_exc_intercept_arb.sv
`timescale 1ns/1ps
module tb_exc_intercept_arb;
  logic        clk, rst_n;
  logic        ev_valid, ev_db_trap, shut_icpt, dlv_done;
  logic [7:0]  ev_vector;
  logic [2:0]  ev_src;
  logic [31:0] ev_errc, exc_mask;
  logic [63:0] ev_fault_addr, ev_ip_cur, ev_ip_next;
  logic        exit_valid, exit_prior_valid, deliver_valid, shutdown;
  logic [7:0]  exit_code, exit_prior_vec, deliver_vec;
  logic [63:0] exit_info1, exit_info2, exit_ip;

  int checks = 0;
  int errors = 0;

  exc_intercept_arb dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_vector(ev_vector),
    .ev_src(ev_src), .ev_errc(ev_errc), .ev_fault_addr(ev_fault_addr),
    .ev_ip_cur(ev_ip_cur), .ev_ip_next(ev_ip_next), .ev_db_trap(ev_db_trap),
    .exc_mask(exc_mask), .shut_icpt(shut_icpt), .dlv_done(dlv_done),
    .exit_valid(exit_valid), .exit_code(exit_code), .exit_info1(exit_info1),
    .exit_info2(exit_info2), .exit_ip(exit_ip),
    .exit_prior_valid(exit_prior_valid), .exit_prior_vec(exit_prior_vec),
    .deliver_valid(deliver_valid), .deliver_vec(deliver_vec),
    .shutdown(shutdown)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  src;
    logic [7:0]  vec;
    logic [31:0] mask;
    logic        trap;
    logic        done;
    logic        xexit;
    logic [7:0]  code;
    logic [1:0]  info_sel;
    logic [1:0]  ip_sel;
    logic        pv;
    logic [7:0]  pvec;
    logic        xdlv;
    logic [7:0]  dvec;
  } row_t;

  localparam int NROW = 19;
  localparam row_t TBL [NROW] = '{
    '{3'd0, 8'd13, 32'h0000_2000, 1'b0, 1'b1, 1'b1, 8'h4D, 2'd1, 2'd1, 1'b0, 8'd0, 1'b0, 8'd0},
    '{3'd0, 8'd14, 32'h0000_4000, 1'b0, 1'b1, 1'b1, 8'h4E, 2'd2, 2'd1, 1'b0, 8'd0, 1'b0, 8'd0},
    '{3'd1, 8'd13, 32'h0000_2000, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd13},
    '{3'd2, 8'd3,  32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd3},
    '{3'd3, 8'd3,  32'h0000_0008, 1'b0, 1'b1, 1'b1, 8'h43, 2'd0, 2'd1, 1'b0, 8'd0, 1'b0, 8'd0},
    '{3'd0, 8'd1,  32'h0000_0002, 1'b1, 1'b1, 1'b1, 8'h41, 2'd0, 2'd2, 1'b0, 8'd0, 1'b0, 8'd0},
    '{3'd0, 8'd1,  32'h0000_0002, 1'b0, 1'b1, 1'b1, 8'h41, 2'd0, 2'd1, 1'b0, 8'd0, 1'b0, 8'd0},
    '{3'd4, 8'd1,  32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd1},
    '{3'd0, 8'd2,  32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd2},
    '{3'd0, 8'd13, 32'h0000_2000, 1'b0, 1'b0, 1'b1, 8'h4D, 2'd1, 2'd1, 1'b1, 8'd2, 1'b0, 8'd0},
    '{3'd0, 8'd0,  32'h0000_0000, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd0},
    '{3'd0, 8'd11, 32'h0000_0100, 1'b0, 1'b0, 1'b1, 8'h48, 2'd0, 2'd0, 1'b0, 8'd0, 1'b0, 8'd0},
    '{3'd0, 8'd0,  32'h0000_0000, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd0},
    '{3'd0, 8'd6,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd8},
    '{3'd0, 8'd17, 32'h0002_0000, 1'b0, 1'b0, 1'b1, 8'h51, 2'd1, 2'd1, 1'b1, 8'd8, 1'b0, 8'd0},
    '{3'd0, 8'd9,  32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd9},
    '{3'd0, 8'd40, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'd0, 1'b1, 8'd40},
    '{3'd0, 8'd10, 32'h0000_0400, 1'b0, 1'b1, 1'b1, 8'h4A, 2'd1, 2'd1, 1'b0, 8'd0, 1'b0, 8'd0},
    '{3'd0, 8'd0,  32'h0000_0001, 1'b0, 1'b1, 1'b1, 8'h40, 2'd0, 2'd1, 1'b0, 8'd0, 1'b0, 8'd0}
  };
  localparam string TAG [NROW] = '{"R9", "R10", "R1", "R1", "R6", "R8", "R8", "R7",
    "R11", "R3", "R2", "R4", "R2", "R4", "R5", "R11", "R11", "R13", "R12"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk) dlv_done = 1'b1;
    @(negedge clk) dlv_done = 1'b0;
  endtask

  task automatic present(input logic [2:0] s, input logic [7:0] v, input logic [31:0] m,
                         input logic t, input int i);
    @(negedge clk);
    ev_src = s; ev_vector = v; exc_mask = m; ev_db_trap = t;
    ev_errc = 32'hE000_0000 | 32'(i);
    ev_fault_addr = 64'hFFFF_A000_0000_0000 + 64'(i);
    ev_ip_cur = 64'h1000 + 64'(i * 16);
    ev_ip_next = 64'h1000 + 64'(i * 16) + 64'd3;
    ev_valid = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle_in();
    @(negedge clk) ev_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ev_valid = 0; ev_vector = 0; ev_src = 0; ev_errc = 0; ev_fault_addr = 0;
    ev_ip_cur = 0; ev_ip_next = 0; ev_db_trap = 0; exc_mask = 0;
    shut_icpt = 0; dlv_done = 0; rst_n = 0;
    #1;
    do_reset();
    // R14: reset state
    chk("R14", {62'd0, exit_valid, deliver_valid}, 64'd0);
    chk("R14", {56'd0, exit_code}, 64'd0);
    chk("R14", exit_ip | exit_info1 | exit_info2, 64'd0);
    chk("R14", {63'd0, shutdown}, 64'd0);

    for (int i = 0; i < NROW; i++) begin
      if (TBL[i].done) pulse_done();
      present(TBL[i].src, TBL[i].vec, TBL[i].mask, TBL[i].trap, i);
      chk(TAG[i], {63'd0, exit_valid}, {63'd0, TBL[i].xexit});
      chk(TAG[i], {63'd0, deliver_valid}, {63'd0, TBL[i].xdlv});
      if (TBL[i].xexit) begin
        chk(TAG[i], {56'd0, exit_code}, {56'd0, TBL[i].code});
        chk(TAG[i], exit_info1, TBL[i].info_sel == 2'd0 ? 64'd0 : {32'd0, ev_errc});
        chk(TAG[i], exit_info2, TBL[i].info_sel == 2'd2 ? ev_fault_addr : 64'd0);
        chk(TAG[i], exit_ip, TBL[i].ip_sel == 2'd0 ? 64'd0 :
                             TBL[i].ip_sel == 2'd1 ? ev_ip_cur : ev_ip_next);
        chk(TAG[i], {63'd0, exit_prior_valid}, {63'd0, TBL[i].pv});
        if (TBL[i].pv) chk(TAG[i], {56'd0, exit_prior_vec}, {56'd0, TBL[i].pvec});
      end
      if (TBL[i].xdlv) chk(TAG[i], {56'd0, deliver_vec}, {56'd0, TBL[i].dvec});
      idle_in();
    end

    // R5: intercepted shutdown
    pulse_done();
    present(3'd0, 8'd0, 32'h0, 1'b0, 50); idle_in();
    present(3'd0, 8'd0, 32'h0, 1'b0, 51); idle_in();
    chk("R5", {56'd0, deliver_vec}, 64'd8);
    shut_icpt = 1'b1;
    present(3'd0, 8'd0, 32'h0, 1'b0, 52);
    chk("R5", {63'd0, exit_valid}, 64'd1);
    chk("R5", {56'd0, exit_code}, 64'h7F);
    chk("R5", {63'd0, shutdown}, 64'd0);
    idle_in();

    // R5: unintercepted shutdown is sticky and swallows events
    shut_icpt = 1'b0;
    present(3'd0, 8'd0, 32'h0, 1'b0, 53); idle_in();
    present(3'd0, 8'd0, 32'h0, 1'b0, 54); idle_in();
    present(3'd0, 8'd0, 32'h0, 1'b0, 55);
    chk("R5", {62'd0, exit_valid, deliver_valid}, 64'd0);
    idle_in();
    @(posedge clk); #1;
    chk("R5", {63'd0, shutdown}, 64'd1);
    pulse_done();
    present(3'd0, 8'd13, 32'h2000, 1'b0, 56);
    chk("R5", {62'd0, exit_valid, deliver_valid}, 64'd0);
    chk("R5", {63'd0, shutdown}, 64'd1);
    idle_in();
    do_reset();
    chk("R14", {63'd0, shutdown}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule